// File: doc/BRIEF.md
# Indexed Palette and Direct-Colour Pixel Formatter

This block turns a pixel word into three 8-bit colour channels. A colour-mode code picks how the word is read. In indexed mode the low byte selects one of 256 programmable 24-bit entries. In 15-bit direct mode, three 5-bit fields are widened to 8 bits each. In 24-bit direct mode, three byte fields are passed straight through. The colour outputs are registered, with one cycle of latency in every mode.

Software programs the table through a byte-wide write port. It first writes the entry number to the index port. It then writes three bytes to the data port: red first, then green, then blue. The entry is only committed when the blue byte arrives. The index then steps to the next entry, so a run of entries can be streamed without re-addressing. The same byte port also reaches an indirect register pair. An address byte selects the register and a following data byte loads it. Register 0x20 holds the mode/control byte and register 0x21 holds the bank select. Both are presented as outputs for the rest of the display pipeline.

Top module: `palette_rgb_unit`

## Requirements
- R1: While rst_ni is low, red_o, grn_o, blu_o, ctrl_reg_o and bank_reg_o are all zero. The load phase returns to red and the entry index returns to 0.
- R2: A CPU write uses cpu_port_i = 0 for the entry index and 1 for the palette data. After the index is written, the three data bytes, taken in the order red, green, blue, become that entry's 24-bit colour.
- R3: A table entry keeps its old value until the blue byte is written. A write to the index port restarts the colour sequence at red, so an incomplete red/green pair is discarded.
- R4: Each blue write advances the entry index by one, so consecutive triples fill consecutive entries. The index wraps from 255 to 0.
- R5: With pix_mode_i = 0 (indexed), pix_i[7:0] selects the entry, and the outputs show its red, green and blue bytes. pix_i[31:8] has no effect.
- R6: With pix_mode_i = 1 (RGB 555), red is pix_i[14:10], green is pix_i[9:5] and blue is pix_i[4:0]. Each 5-bit field c becomes {c, c[4:2]}. pix_i[31:15] has no effect.
- R7: With pix_mode_i = 2 (RGB 888), red is pix_i[23:16], green is pix_i[15:8] and blue is pix_i[7:0]. pix_i[31:24] has no effect.
- R8: The colour outputs change one clock edge after pix_i and pix_mode_i are sampled. This holds in every mode, including when the mode changes from one cycle to the next.
- R9: A write with cpu_port_i = 2 stores a register address. A write with cpu_port_i = 3 loads the addressed register: 0x20 drives ctrl_reg_o and 0x21 drives bank_reg_o. The stored address is kept, so repeated data writes go to the same register. Data written to any other address changes neither output.
- R10: With pix_mode_i = 3 (reserved), all three colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_we_i | input | 1 | Byte write strobe, one write per cycle |
| cpu_port_i | input | 2 | 0 entry index, 1 palette data, 2 register address, 3 register data |
| cpu_wdata_i | input | 8 | Write byte |
| pix_i | input | 32 | Pixel word |
| pix_mode_i | input | 2 | 0 indexed, 1 RGB 555, 2 RGB 888, 3 reserved (black) |
| red_o | output | 8 | Registered red channel |
| grn_o | output | 8 | Registered green channel |
| blu_o | output | 8 | Registered blue channel |
| ctrl_reg_o | output | 8 | Indirect register 0x20 |
| bank_reg_o | output | 8 | Indirect register 0x21 |

## Verification
The bench abandons a triple after red and green and then re-addresses the same entry. A design that committed bytes one at a time, or that failed to restart the phase, would show a torn colour or channels shifted by one position. Streaming across entries 254, 255 and 0 exposes a missing auto-increment or a bad wrap, which would overwrite one entry or drop the third. The direct modes use field values with distinct top bits and set the ignored high bits to ones. A wrong replication or a field taken from the wrong position therefore gives visibly wrong bytes. The bench also changes mode on every cycle, which catches a mode mux that lags the data by one cycle. On the register side, data sent to an unused address must leave both register outputs unchanged, and repeated data writes must keep landing on the stored address.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef enum logic [1:0] {
    PM_INDEX  = 2'd0,
    PM_RGB555 = 2'd1,
    PM_RGB888 = 2'd2,
    PM_BLANK  = 2'd3
  } pix_mode_e;

  typedef enum logic [1:0] {
    PORT_IDX   = 2'd0,
    PORT_DATA  = 2'd1,
    PORT_RADDR = 2'd2,
    PORT_RDATA = 2'd3
  } cpu_port_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/pal_loader.sv
module pal_loader
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  cpu_port_e        port_i,
  input  logic [CH_W-1:0]  wdata_i,
  output logic             commit_o,
  output logic [IDX_W-1:0] idx_o,
  output rgb_t             entry_o,
  output phase_e           phase_o
);
  logic [IDX_W-1:0] idx_q;
  logic [CH_W-1:0]  red_q, grn_q;
  phase_e           phase_q;
  logic             data_wr;

  assign data_wr = we_i && (port_i == PORT_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      red_q   <= '0;
      grn_q   <= '0;
      phase_q <= PH_RED;
    end else if (we_i && port_i == PORT_IDX) begin
      idx_q   <= wdata_i[IDX_W-1:0];
      phase_q <= PH_RED;
    end else if (data_wr) begin
      unique case (phase_q)
        PH_GRN: begin
          grn_q   <= wdata_i;
          phase_q <= PH_BLU;
        end
        PH_BLU: begin
          idx_q   <= idx_q + 1'b1;
          phase_q <= PH_RED;
        end
        default: begin
          red_q   <= wdata_i;
          phase_q <= PH_GRN;
        end
      endcase
    end
  end

  // Whole entry lands at once on the blue byte
  assign commit_o = data_wr && (phase_q == PH_BLU);
  assign entry_o  = '{r: red_q, g: grn_q, b: wdata_i};
  assign idx_o    = idx_q;
  assign phase_o  = phase_q;
endmodule

// File: rtl/pal_table.sv
module pal_table
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  rgb_t             wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output rgb_t             rdata_o
);
  localparam int ENTRIES = 1 << IDX_W;

  rgb_t mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/pal_indirect_regs.sv
module pal_indirect_regs
  import pal_pkg::*;
#(
  parameter logic [CH_W-1:0] CTRL_ADDR = 8'h20,
  parameter logic [CH_W-1:0] BANK_ADDR = 8'h21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  cpu_port_e       port_i,
  input  logic [CH_W-1:0] wdata_i,
  output logic [CH_W-1:0] addr_o,
  output logic [CH_W-1:0] ctrl_o,
  output logic [CH_W-1:0] bank_o
);
  logic [CH_W-1:0] addr_q, ctrl_q, bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ctrl_q <= '0;
      bank_q <= '0;
    end else if (we_i) begin
      if (port_i == PORT_RADDR) addr_q <= wdata_i;
      if (port_i == PORT_RDATA) begin
        if (addr_q == CTRL_ADDR) ctrl_q <= wdata_i;
        if (addr_q == BANK_ADDR) bank_q <= wdata_i;
      end
    end
  end

  assign addr_o = addr_q;
  assign ctrl_o = ctrl_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/pal_formatter.sv
module pal_formatter
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PIX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  pix_mode_e        mode_i,
  input  rgb_t             lut_i,
  output logic [IDX_W-1:0] lut_idx_o,
  output rgb_t             rgb_o
);
  localparam int F5 = 5;

  function automatic logic [CH_W-1:0] widen5(input logic [F5-1:0] c);
    return {c, c[F5-1:F5-(CH_W-F5)]};
  endfunction

  rgb_t rgb_d, rgb_q;
  logic unused_pix_hi;

  assign unused_pix_hi = ^pix_i[PIX_W-1:3*CH_W];
  assign lut_idx_o     = pix_i[IDX_W-1:0];

  always_comb begin
    unique case (mode_i)
      PM_INDEX:  rgb_d = lut_i;
      PM_RGB555: rgb_d = '{r: widen5(pix_i[3*F5-1:2*F5]),
                           g: widen5(pix_i[2*F5-1:F5]),
                           b: widen5(pix_i[F5-1:0])};
      PM_RGB888: rgb_d = '{r: pix_i[3*CH_W-1:2*CH_W],
                           g: pix_i[2*CH_W-1:CH_W],
                           b: pix_i[CH_W-1:0]};
      default:   rgb_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= '0;
    else         rgb_q <= rgb_d;
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/palette_rgb_unit.sv
module palette_rgb_unit
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PIX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_we_i,
  input  logic [1:0]       cpu_port_i,
  input  logic [CH_W-1:0]  cpu_wdata_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [1:0]       pix_mode_i,
  output logic [CH_W-1:0]  red_o,
  output logic [CH_W-1:0]  grn_o,
  output logic [CH_W-1:0]  blu_o,
  output logic [CH_W-1:0]  ctrl_reg_o,
  output logic [CH_W-1:0]  bank_reg_o
);
  cpu_port_e        port;
  pix_mode_e        mode;
  logic             ld_commit;
  logic [IDX_W-1:0] ld_idx;
  rgb_t             ld_entry;
  phase_e           ld_phase;
  logic [IDX_W-1:0] rd_idx;
  rgb_t             rd_entry;
  rgb_t             rgb;
  logic [CH_W-1:0]  rg_addr;

  assign port = cpu_port_e'(cpu_port_i);
  assign mode = pix_mode_e'(pix_mode_i);

  pal_loader #(.IDX_W(IDX_W)) u_loader (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cpu_we_i),
    .port_i   (port),
    .wdata_i  (cpu_wdata_i),
    .commit_o (ld_commit),
    .idx_o    (ld_idx),
    .entry_o  (ld_entry),
    .phase_o  (ld_phase)
  );

  pal_table #(.IDX_W(IDX_W)) u_table (
    .clk_i   (clk_i),
    .we_i    (ld_commit),
    .widx_i  (ld_idx),
    .wdata_i (ld_entry),
    .ridx_i  (rd_idx),
    .rdata_o (rd_entry)
  );

  pal_indirect_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cpu_we_i),
    .port_i  (port),
    .wdata_i (cpu_wdata_i),
    .addr_o  (rg_addr),
    .ctrl_o  (ctrl_reg_o),
    .bank_o  (bank_reg_o)
  );

  pal_formatter #(.IDX_W(IDX_W), .PIX_W(PIX_W)) u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_i     (pix_i),
    .mode_i    (mode),
    .lut_i     (rd_entry),
    .lut_idx_o (rd_idx),
    .rgb_o     (rgb)
  );

  assign red_o = rgb.r;
  assign grn_o = rgb.g;
  assign blu_o = rgb.b;
endmodule

// File: rtl/palette_rgb_unit_chk.sv
module palette_rgb_unit_chk
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PIX_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_we_i,
  input logic [1:0]       cpu_port_i,
  input logic [CH_W-1:0]  cpu_wdata_i,
  input logic [PIX_W-1:0] pix_i,
  input logic [1:0]       pix_mode_i,
  input logic [CH_W-1:0]  red_o,
  input logic [CH_W-1:0]  grn_o,
  input logic [CH_W-1:0]  blu_o,
  input logic [CH_W-1:0]  ctrl_reg_o,
  input logic [CH_W-1:0]  bank_reg_o,
  input phase_e           phase,
  input logic [IDX_W-1:0] idx,
  input logic             commit,
  input logic [CH_W-1:0]  reg_addr
);
  a_r1_reset_outputs: assert property (@(posedge clk_i)
    !rst_ni |=> (red_o == '0 && grn_o == '0 && blu_o == '0 &&
                 ctrl_reg_o == '0 && bank_reg_o == '0));

  a_r3_index_restarts_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_port_i == 2'd0) |=>
      (phase == PH_RED && idx == $past(cpu_wdata_i[IDX_W-1:0])));

  a_r4_auto_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (phase == PH_RED && idx == IDX_W'($past(idx) + 1'b1)));

  a_r6_rgb555_widen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_mode_i == 2'd1) |=>
      (red_o == {$past(pix_i[14:10]), $past(pix_i[14:12])} &&
       blu_o == {$past(pix_i[4:0]), $past(pix_i[4:2])}));

  a_r8_rgb888_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_mode_i == 2'd2) |=>
      (red_o == $past(pix_i[23:16]) && grn_o == $past(pix_i[15:8]) &&
       blu_o == $past(pix_i[7:0])));

  a_r9_other_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_port_i == 2'd3 && reg_addr != 8'h20 && reg_addr != 8'h21) |=>
      ($stable(ctrl_reg_o) && $stable(bank_reg_o)));

  a_r10_reserved_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_mode_i == 2'd3) |=> (red_o == '0 && grn_o == '0 && blu_o == '0));
endmodule

bind palette_rgb_unit palette_rgb_unit_chk #(.IDX_W(IDX_W), .PIX_W(PIX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_we_i    (cpu_we_i),
  .cpu_port_i  (cpu_port_i),
  .cpu_wdata_i (cpu_wdata_i),
  .pix_i       (pix_i),
  .pix_mode_i  (pix_mode_i),
  .red_o       (red_o),
  .grn_o       (grn_o),
  .blu_o       (blu_o),
  .ctrl_reg_o  (ctrl_reg_o),
  .bank_reg_o  (bank_reg_o),
  .phase       (ld_phase),
  .idx         (ld_idx),
  .commit      (ld_commit),
  .reg_addr    (rg_addr)
);

// File: tb/palette_rgb_unit_tb.sv
module palette_rgb_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [1:0]  cpu_port_i = 2'd0;
  logic [7:0]  cpu_wdata_i = 8'd0;
  logic [31:0] pix_i = 32'd0;
  logic [1:0]  pix_mode_i = 2'd3;
  logic [7:0]  red_o, grn_o, blu_o, ctrl_reg_o, bank_reg_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  palette_rgb_unit u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_we_i    (cpu_we_i),
    .cpu_port_i  (cpu_port_i),
    .cpu_wdata_i (cpu_wdata_i),
    .pix_i       (pix_i),
    .pix_mode_i  (pix_mode_i),
    .red_o       (red_o),
    .grn_o       (grn_o),
    .blu_o       (blu_o),
    .ctrl_reg_o  (ctrl_reg_o),
    .bank_reg_o  (bank_reg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] port, input logic [7:0] data);
    @(negedge clk_i);
    cpu_we_i = 1'b1; cpu_port_i = port; cpu_wdata_i = data;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic load(input logic [7:0] idx, input logic [23:0] rgb);
    cpu_wr(2'd0, idx);
    cpu_wr(2'd1, rgb[23:16]);
    cpu_wr(2'd1, rgb[15:8]);
    cpu_wr(2'd1, rgb[7:0]);
  endtask

  task automatic look(input logic [1:0] mode, input logic [31:0] pix, output logic [23:0] rgb);
    @(negedge clk_i);
    pix_mode_i = mode; pix_i = pix;
    @(negedge clk_i);
    rgb = {red_o, grn_o, blu_o};
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk("R1 rgb", {8'h0, red_o, grn_o, blu_o}, 32'h0);
    chk("R1 ctrl", {24'h0, ctrl_reg_o}, 32'h0);
    chk("R1 bank", {24'h0, bank_reg_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_load;
    logic [23:0] c;
    load(8'd5, 24'h112233);
    look(2'd0, 32'h0000_0005, c);
    chk("R2 entry5", {8'h0, c}, 32'h112233);
    // R5: upper pixel bits ignored in indexed mode
    look(2'd0, 32'hFFFF_FF05, c);
    chk("R5 upper ignored", {8'h0, c}, 32'h112233);
  endtask

  task automatic t_partial;
    logic [23:0] c;
    load(8'd10, 24'hAABBCC);
    cpu_wr(2'd0, 8'd10);
    cpu_wr(2'd1, 8'h01);
    cpu_wr(2'd1, 8'h02);
    look(2'd0, 32'd10, c);
    chk("R3 partial no commit", {8'h0, c}, 32'hAABBCC);
    load(8'd10, 24'h405060);
    look(2'd0, 32'd10, c);
    chk("R3 phase restart", {8'h0, c}, 32'h405060);
  endtask

  task automatic t_stream;
    logic [23:0] c;
    cpu_wr(2'd0, 8'd254);
    cpu_wr(2'd1, 8'h01); cpu_wr(2'd1, 8'h02); cpu_wr(2'd1, 8'h03);
    cpu_wr(2'd1, 8'h04); cpu_wr(2'd1, 8'h05); cpu_wr(2'd1, 8'h06);
    cpu_wr(2'd1, 8'h07); cpu_wr(2'd1, 8'h08); cpu_wr(2'd1, 8'h09);
    look(2'd0, 32'd254, c);
    chk("R4 entry254", {8'h0, c}, 32'h010203);
    look(2'd0, 32'd255, c);
    chk("R4 entry255", {8'h0, c}, 32'h040506);
    look(2'd0, 32'd0, c);
    chk("R4 wrap entry0", {8'h0, c}, 32'h070809);
    look(2'd0, 32'd5, c);
    chk("R4 entry5 untouched", {8'h0, c}, 32'h112233);
  endtask

  task automatic t_direct;
    logic [23:0] c;
    look(2'd1, 32'hFFFF_CCD9, c);
    chk("R6 rgb555", {8'h0, c}, 32'h9C31CE);
    look(2'd2, 32'hA512_3456, c);
    chk("R7 rgb888", {8'h0, c}, 32'h123456);
    look(2'd3, 32'hFFFF_FFFF, c);
    chk("R10 reserved black", {8'h0, c}, 32'h0);
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    pix_mode_i = 2'd2; pix_i = 32'h0010_2030;
    @(negedge clk_i);
    chk("R8 888 first", {8'h0, red_o, grn_o, blu_o}, 32'h102030);
    pix_mode_i = 2'd1; pix_i = 32'h0000_7FFF;
    @(negedge clk_i);
    chk("R8 555 next", {8'h0, red_o, grn_o, blu_o}, 32'hFFFFFF);
    pix_mode_i = 2'd0; pix_i = 32'd10;
    @(negedge clk_i);
    chk("R8 index next", {8'h0, red_o, grn_o, blu_o}, 32'h405060);
  endtask

  task automatic t_regs;
    cpu_wr(2'd2, 8'h20); cpu_wr(2'd3, 8'h5A);
    cpu_wr(2'd2, 8'h21); cpu_wr(2'd3, 8'h03);
    chk("R9 ctrl", {24'h0, ctrl_reg_o}, 32'h5A);
    chk("R9 bank", {24'h0, bank_reg_o}, 32'h03);
    cpu_wr(2'd2, 8'h22); cpu_wr(2'd3, 8'hFF);
    chk("R9 other ctrl", {24'h0, ctrl_reg_o}, 32'h5A);
    chk("R9 other bank", {24'h0, bank_reg_o}, 32'h03);
    cpu_wr(2'd2, 8'h20); cpu_wr(2'd3, 8'h11); cpu_wr(2'd3, 8'h22);
    chk("R9 repeat data", {24'h0, ctrl_reg_o}, 32'h22);
    chk("R9 bank kept", {24'h0, bank_reg_o}, 32'h03);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_load;
    t_partial;
    t_stream;
    t_direct;
    t_latency;
    t_regs;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run;
  end
endmodule